// File: doc/BRIEF.md
# Staged Control-Word Loader

This block lets a byte-wide host assemble a 24-bit control word without the consumer ever seeing it half-written. The host stores bytes into three holding registers, one per address 0 to 2. A write of any data to address 3 is a commit. It copies all three holding bytes into the active control word on one clock edge. A one-cycle pulse marks every commit that is accepted.

The active word is presented as decoded fields:
- a 12-bit frequency-select value,
- a direction bit,
- an overmodulation bit,
- an output-enable bit, which leaves the outputs inhibited when it is 0,
- an 8-bit amplitude value.

Commits are refused until the host signals that the basic operating parameters are in place. Writes to the holding registers are always taken. Reset clears every register, so the outputs come up inhibited.

Top module: `staged_ctrl_loader`

## Requirements
- R1: After reset, all decoded outputs are 0 and `xfer_pulse_o` is 0. In particular `drive_en_o` is 0, which means the outputs are inhibited.
- R2: A write to address 0, 1 or 2 updates only its holding byte. No decoded output changes as a result.
- R3: A write with `addr_i`=3 while `init_done_i`=1 copies all three holding bytes into the active word on that clock edge. The data on `wdata_i` is ignored. The outputs show the new value from the following cycle.
- R4: `freq_sel_o` is {holding byte 1 bits 3:0, holding byte 0 bits 7:0}, with bit 0 of byte 0 as the LSB.
- R5: Byte 1 carries three control bits: bit 7 drives `reverse_o` (0 = forward), bit 6 drives `overmod_o` (1 = active) and bit 5 drives `drive_en_o` (0 = outputs inhibited). Bit 4 of byte 1 has no effect on any output.
- R6: `amplitude_o` equals holding byte 2 as of the last accepted commit.
- R7: A write with `addr_i`=3 while `init_done_i`=0 leaves every decoded output unchanged and raises no pulse. The holding bytes are kept.
- R8: `xfer_pulse_o` is high for exactly the one cycle after each accepted commit, and is low at all other times.
- R9: When `wr_en_i`=0, neither the holding bytes nor the active word change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 2 | 0 to 2 select a holding byte; 3 is the commit address |
| wdata_i | input | 8 | Write data |
| init_done_i | input | 1 | High once the operating parameters are loaded; enables commits |
| freq_sel_o | output | 12 | Frequency-select value |
| reverse_o | output | 1 | Direction: 0 = forward, 1 = reverse |
| overmod_o | output | 1 | Overmodulation: 1 = active |
| drive_en_o | output | 1 | Output enable: 0 = outputs inhibited |
| amplitude_o | output | 8 | Amplitude value |
| xfer_pulse_o | output | 1 | One-cycle flag for an accepted commit |

## Verification
A corrupted holding byte stays hidden until the next accepted commit. At that point it shows up in the cycle after the commit, in the field decoded from that byte. The bench therefore checks every field right after each commit, as well as after holding writes and refused commits.

A wrong commit decision shows up at once, in the very next cycle. It appears either as a missing or spurious `xfer_pulse_o`, or as fields that move when they should hold. Directed cases cover:
- a commit refused before `init_done_i`,
- a toggle of the don't-care bit,
- the all-ones frequency value.

// File: rtl/ctrl_loader_pkg.sv
package ctrl_loader_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_HOLD   = 3;
  localparam int ADDR_W   = 2;
  localparam int WORD_W   = BYTE_W * N_HOLD;
  localparam int FREQ_W   = 12;
  localparam int FREQ_HI  = FREQ_W - BYTE_W;
  localparam int REV_BIT  = 7;
  localparam int OVM_BIT  = 6;
  localparam int ENA_BIT  = 5;

  typedef struct packed {
    logic              reverse;
    logic              overmod;
    logic              drive_en;
    logic [FREQ_W-1:0] freq;
    logic [BYTE_W-1:0] amp;
  } ctrl_fields_t;
endpackage

// File: rtl/ctrl_hold_regs.sv
module ctrl_hold_regs #(
  parameter int BYTE_W = 8,
  parameter int N_HOLD = 3,
  parameter int ADDR_W = 2,
  localparam int WORD_W = BYTE_W * N_HOLD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WORD_W-1:0] hold_o
);
  for (genvar i = 0; i < N_HOLD; i++) begin : g_hold
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(i))        q <= wdata_i;
    end
    assign hold_o[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/ctrl_commit_stage.sv
module ctrl_commit_stage #(
  parameter int WORD_W      = 24,
  parameter int ADDR_W      = 2,
  parameter int COMMIT_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              init_done_i,
  input  logic [WORD_W-1:0] hold_i,
  output logic [WORD_W-1:0] active_o,
  output logic              xfer_o
);
  logic commit;
  assign commit = wr_en_i && init_done_i && (addr_i == ADDR_W'(COMMIT_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      xfer_o   <= 1'b0;
    end else begin
      xfer_o <= commit;
      if (commit) active_o <= hold_i;
    end
  end
endmodule

// File: rtl/ctrl_field_decode.sv
module ctrl_field_decode
  import ctrl_loader_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output ctrl_fields_t      fields_o
);
  logic [BYTE_W-1:0] b0, b1, b2;
  assign b0 = word_i[0*BYTE_W +: BYTE_W];
  assign b1 = word_i[1*BYTE_W +: BYTE_W];
  assign b2 = word_i[2*BYTE_W +: BYTE_W];

  always_comb begin
    fields_o.freq     = {b1[FREQ_HI-1:0], b0};
    fields_o.reverse  = b1[REV_BIT];
    fields_o.overmod  = b1[OVM_BIT];
    fields_o.drive_en = b1[ENA_BIT];
    fields_o.amp      = b2;
  end
endmodule

// File: rtl/staged_ctrl_loader.sv
module staged_ctrl_loader
  import ctrl_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              init_done_i,
  output logic [FREQ_W-1:0] freq_sel_o,
  output logic              reverse_o,
  output logic              overmod_o,
  output logic              drive_en_o,
  output logic [BYTE_W-1:0] amplitude_o,
  output logic              xfer_pulse_o
);
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] active_word;
  ctrl_fields_t      fields;

  ctrl_hold_regs #(.BYTE_W(BYTE_W), .N_HOLD(N_HOLD), .ADDR_W(ADDR_W)) u_hold (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .hold_o(hold_word)
  );

  ctrl_commit_stage #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .COMMIT_ADDR(N_HOLD)) u_commit (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .init_done_i,
    .hold_i(hold_word), .active_o(active_word), .xfer_o(xfer_pulse_o)
  );

  ctrl_field_decode u_dec (.word_i(active_word), .fields_o(fields));

  assign freq_sel_o  = fields.freq;
  assign reverse_o   = fields.reverse;
  assign overmod_o   = fields.overmod;
  assign drive_en_o  = fields.drive_en;
  assign amplitude_o = fields.amp;
endmodule

// File: rtl/staged_ctrl_loader_chk.sv
module staged_ctrl_loader_chk
  import ctrl_loader_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              init_done_i,
  input logic [WORD_W-1:0] hold_word,
  input logic [FREQ_W-1:0] freq_sel_o,
  input logic              reverse_o,
  input logic              overmod_o,
  input logic              drive_en_o,
  input logic [BYTE_W-1:0] amplitude_o,
  input logic              xfer_pulse_o
);
  logic commit_req;
  assign commit_req = wr_en_i && init_done_i && (addr_i == ADDR_W'(N_HOLD));

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_req |=> $stable({freq_sel_o, reverse_o, overmod_o, drive_en_o, amplitude_o}))
    else $error("outputs moved without commit"); // R2

  AST_PULSE_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req |=> xfer_pulse_o) else $error("missing pulse"); // R8

  AST_NO_STRAY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_req |=> !xfer_pulse_o) else $error("stray pulse"); // R7

  AST_FREQ_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req |=> freq_sel_o == {$past(hold_word[BYTE_W +: FREQ_HI]), $past(hold_word[0 +: BYTE_W])})
    else $error("freq copy"); // R4

  AST_CTRL_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req |=> {reverse_o, overmod_o, drive_en_o} ==
                   $past(hold_word[BYTE_W+ENA_BIT +: 3]))
    else $error("control bits copy"); // R5

  AST_AMP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req |=> amplitude_o == $past(hold_word[2*BYTE_W +: BYTE_W]))
    else $error("amplitude copy"); // R6
endmodule

bind staged_ctrl_loader staged_ctrl_loader_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .init_done_i, .hold_word,
  .freq_sel_o, .reverse_o, .overmod_o, .drive_en_o, .amplitude_o, .xfer_pulse_o
);

// File: tb/staged_ctrl_loader_bench.sv
module staged_ctrl_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        init_done = 1'b0;
  logic [11:0] freq_sel;
  logic        reverse, overmod, drive_en, xfer_pulse;
  logic [7:0]  amplitude;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] hold [3];
  logic [7:0] act  [3];

  always #5 clk = ~clk;

  staged_ctrl_loader u_staged_ctrl_loader (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .init_done_i(init_done), .freq_sel_o(freq_sel), .reverse_o(reverse),
    .overmod_o(overmod), .drive_en_o(drive_en), .amplitude_o(amplitude),
    .xfer_pulse_o(xfer_pulse)
  );

  function automatic logic [11:0] exp_freq();
    return {act[1][3:0], act[0]};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req, input logic pulse_exp);
    chk(req, "freq_sel", int'(freq_sel), int'(exp_freq()));
    chk(req, "reverse",  int'(reverse),  int'(act[1][7]));
    chk(req, "overmod",  int'(overmod),  int'(act[1][6]));
    chk(req, "drive_en", int'(drive_en), int'(act[1][5]));
    chk(req, "amplitude", int'(amplitude), int'(act[2]));
    chk(req, "xfer_pulse", int'(xfer_pulse), int'(pulse_exp));
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d, input logic init,
                       input logic en, input string req);
    logic acc;
    @(negedge clk);
    wr_en = en; addr = a; wdata = d; init_done = init;
    @(negedge clk);
    wr_en = 1'b0;
    acc = en && init && (a == 2'd3);
    if (acc) for (int i = 0; i < 3; i++) act[i] = hold[i];
    if (en && a != 2'd3) hold[a] = d;
    check_all(req, acc);
  endtask

  task automatic load(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    do_wr(2'd0, b0, 1'b1, 1'b1, "R2");
    do_wr(2'd1, b1, 1'b1, 1'b1, "R2");
    do_wr(2'd2, b2, 1'b1, 1'b1, "R2");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3; i++) begin hold[i] = '0; act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, inhibit asserted
    check_all("R1", 1'b0);

    // R7: commit refused before init
    load(8'hA5, 8'hEF, 8'h3C);
    do_wr(2'd3, 8'hFF, 1'b0, 1'b1, "R7");
    @(negedge clk); check_all("R7", 1'b0);

    // R3 R4 R5 R6: accepted commit, data byte ignored
    do_wr(2'd3, 8'h00, 1'b1, 1'b1, "R3");
    @(negedge clk); check_all("R8", 1'b0);

    // R9: strobe low does nothing
    do_wr(2'd3, 8'h00, 1'b1, 1'b0, "R9");
    do_wr(2'd0, 8'h11, 1'b1, 1'b0, "R9");
    do_wr(2'd3, 8'h00, 1'b1, 1'b1, "R9");

    // R5: bit 4 of byte 1 has no effect
    load(8'h00, 8'h00, 8'h00);
    do_wr(2'd3, 8'h00, 1'b1, 1'b1, "R5");
    do_wr(2'd1, 8'h10, 1'b1, 1'b1, "R5");
    do_wr(2'd3, 8'h00, 1'b1, 1'b1, "R5");
    chk("R5", "bit4 freq", int'(freq_sel), 0);
    chk("R5", "bit4 ctrl", int'({reverse, overmod, drive_en}), 0);

    // R4: full-scale frequency
    load(8'hFF, 8'h2F, 8'h80);
    do_wr(2'd3, 8'h5A, 1'b1, 1'b1, "R4");
    chk("R4", "freq max", int'(freq_sel), 12'hFFF);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic init, en;
      a    = 2'($urandom_range(0, 3));
      d    = 8'($urandom);
      init = ($urandom_range(0, 9) != 0);
      en   = ($urandom_range(0, 7) != 0);
      do_wr(a, d, init, en, (a == 2'd3) ? "R3" : "R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule